// File: doc/BRIEF.md
# Serial Transmit Path with Holding Register and Queue

This block is the sending half of a classic asynchronous serial channel. A host writes one byte at a time. The block turns each byte into a line frame: a low start bit, then 5 to 8 data bits with bit 0 first, then an optional parity bit, then one or two high stop bits. Between frames the line rests high. The frame shape comes from plain inputs and is captured when a byte enters the shifter. Bit timing comes from an enable pulse that runs at sixteen times the baud rate.

One mode input picks how writes are stored. With the queue off, there is a single holding slot. With the queue on, up to sixteen bytes wait in write order. Toggling that input throws away whatever is waiting. Two status outputs report that nothing is waiting and that the line has gone fully quiet. A transmit-empty interrupt, gated by an enable input, tells the host it can refill. A write that finds no room is dropped and latches an overflow flag.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, txd is 1, thr_empty and tx_empty are 1, and txe_irq and overflow are 0.
- R2: A frame is one 0 start bit, then N data bits with bit 0 first, then stop bits of value 1; N = 5 + data_sel (data_sel 2'b00 gives 5 bits, 2'b11 gives 8). two_stop=1 sends two stop bits and 0 sends one. The idle line is 1.
- R3: With parity_en=1, one parity bit follows the data bits. parity_odd=0 makes the count of ones over the data bits and the parity bit even; parity_odd=1 makes it odd.
- R4: Every line bit lasts exactly 16 tick16 pulses, and txd changes only on clock edges where tick16 is 1.
- R5: With fifo_en=0 the block holds a single byte. thr_empty drops on the write and rises again when the shifter takes the byte. A second byte may wait while the first is on the line.
- R6: With fifo_en=1, up to 16 bytes are held and sent in write order. thr_empty is 1 exactly when none are waiting.
- R7: A write that arrives when the holding store is full (1 byte with fifo_en=0, 16 bytes with fifo_en=1) is dropped without changing the stored bytes. It sets overflow, which stays at 1 until reset.
- R8: tx_empty is 1 only when no byte is waiting and the shifter is idle. It stays 0 while a frame is still going out, even if thr_empty is already 1.
- R9: Each change of the holding store from non-empty to empty makes a transmit-empty event pending. txe_irq is 1 when an event is pending and irq_en is 1.
- R10: A pending event is cleared by a host write, or by a one-cycle isr_rd pulse while txe_irq is 1.
- R11: When another byte is waiting, its start bit begins on the same tick that ends the last stop bit. Frame starts are therefore spaced by exactly 16 ticks per frame bit.
- R12: Changing fifo_en discards every waiting byte. thr_empty reads 1 on the next cycle, and none of the discarded bytes is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single holding slot |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to send |
| data_sel | input | 2 | Data length: 5 + data_sel bits |
| parity_en | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | 1 odd parity, 0 even |
| two_stop | input | 1 | 1 sends two stop bits |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| isr_rd | input | 1 | Host read of interrupt status |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | No byte waiting |
| tx_empty | output | 1 | Nothing waiting and shifter idle |
| txe_irq | output | 1 | Transmit-empty interrupt |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench fills the queue with all ticks stopped and then pushes one extra byte. A design that took that byte, or wrapped its pointer, would send a stray or reordered frame, and the scoreboard would catch it. Back-to-back frames are timed from start edge to start edge. An extra idle bit between frames, or a load that waits for the next tick, would shift that spacing by a whole bit. Odd parity with two stop bits on 5-bit data checks the parity sense and the stop count at the data-width boundary. The bench also clears the queue by changing mode and then lets the line run. A design that kept the discarded bytes would send frames that no one expects, and one that held the interrupt as a level would miss the clear on a status read.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int SUB_W      = $clog2(OVERSAMPLE);
    localparam int FRAME_W    = 12;
    localparam int IDX_W      = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [SUB_W-1:0]   sub;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [FRAME_W-1:0] frame;
    } shift_st_t;

    typedef struct packed {
        logic prev_empty;
        logic pending;
    } irq_st_t;

    function automatic int data_len(input logic [1:0] sel);
        return 5 + int'(sel);
    endfunction

    // Lay out a full frame with bit 0 on the line first; unused high bits stay 1.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [7:0] data,
        input logic [1:0] sel,
        input logic       pen,
        input logic       podd
    );
        logic [FRAME_W-1:0] f;
        logic               par;
        int                 n;
        f    = '1;
        f[0] = 1'b0;
        n    = data_len(sel);
        par  = podd;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                f[1 + i] = data[i];
                par      = par ^ data[i];
            end
        end
        if (pen) begin
            f[1 + n] = par;
        end
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] last_index(
        input logic [1:0] sel,
        input logic       pen,
        input logic       two
    );
        int total;
        total = 1 + data_len(sel) + (pen ? 1 : 0) + (two ? 2 : 1);
        return IDX_W'(total - 1);
    endfunction

endpackage

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic          overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     mode;
        logic                     ovf;
    } store_st_t;

    store_st_t st_q, st_d;
    logic      flush;
    logic      do_wr;
    logic      do_rd;
    logic [CW-1:0] cap;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        flush = (fifo_en != st_q.mode);
        cap   = st_q.mode ? CW'(DEPTH) : CW'(1);
        full  = (st_q.cnt >= cap);
        do_wr = wr_en && !full && !flush;
        do_rd = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.cnt  = '0;
            st_d.mode = fifo_en;
        end else begin
            if (do_wr) begin
                st_d.mem[st_q.wp] = wr_data;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_rd) begin
                st_d.rp = bump(st_q.rp);
            end
            st_d.cnt = st_q.cnt + CW'(do_wr) - CW'(do_rd);
        end
        if (wr_en && full && !flush) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.mem[st_q.rp];
    assign empty    = (st_q.cnt == '0);
    assign overflow = st_q.ovf;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R6
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> st_q.cnt <= CW'(1)); // R5
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !flush && !pop) |=> $stable(st_q.cnt)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R7
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R12

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       avail,
    input  logic [7:0] din,
    input  logic [1:0] data_sel,
    input  logic       parity_en,
    input  logic       parity_odd,
    input  logic       two_stop,
    output logic       pop,
    output logic       busy,
    output logic       txd
);
    shift_st_t sh_q, sh_d;
    logic      load;

    always_comb begin
        sh_d = sh_q;
        load = 1'b0;
        if (tick) begin
            if (!sh_q.busy) begin
                load = avail;
            end else if (sh_q.sub == SUB_W'(OVERSAMPLE - 1)) begin
                if (sh_q.idx == sh_q.last) begin
                    load = avail;
                    if (!avail) begin
                        sh_d.busy  = 1'b0;
                        sh_d.frame = '1;
                        sh_d.sub   = '0;
                        sh_d.idx   = '0;
                    end
                end else begin
                    sh_d.frame = {1'b1, sh_q.frame[FRAME_W-1:1]};
                    sh_d.idx   = sh_q.idx + IDX_W'(1);
                    sh_d.sub   = '0;
                end
            end else begin
                sh_d.sub = sh_q.sub + SUB_W'(1);
            end
        end
        if (load) begin
            sh_d.busy  = 1'b1;
            sh_d.sub   = '0;
            sh_d.idx   = '0;
            sh_d.last  = last_index(data_sel, parity_en, two_stop);
            sh_d.frame = build_frame(din, data_sel, parity_en, parity_odd);
        end
        pop = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            sh_q.frame <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy = sh_q.busy;
    assign txd  = sh_q.frame[0];

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R2
    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd)); // R4
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (tick && avail)); // R11
    AST_INDEX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> sh_q.idx <= sh_q.last); // R2

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
    import uart_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic wr_en,
    input  logic isr_rd,
    input  logic irq_en,
    output logic irq
);
    irq_st_t ir_q, ir_d;

    always_comb begin
        ir_d            = ir_q;
        ir_d.prev_empty = empty;
        if (empty && !ir_q.prev_empty) begin
            ir_d.pending = 1'b1;
        end
        if (wr_en || (isr_rd && ir_q.pending && irq_en)) begin
            ir_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q.prev_empty <= 1'b1;
            ir_q.pending    <= 1'b0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign irq = ir_q.pending && irq_en;

    AST_IRQ_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ir_q.pending |-> empty); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && irq) |=> !irq); // R10
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq); // R10

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       fifo_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] data_sel,
    input  logic       parity_en,
    input  logic       parity_odd,
    input  logic       two_stop,
    input  logic       irq_en,
    input  logic       isr_rd,
    output logic       txd,
    output logic       thr_empty,
    output logic       tx_empty,
    output logic       txe_irq,
    output logic       overflow
);
    logic [7:0] head_byte;
    logic       store_empty;
    logic       store_full;
    logic       pop;
    logic       busy;

    uart_tx_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pop      (pop),
        .rd_data  (head_byte),
        .empty    (store_empty),
        .full     (store_full),
        .overflow (overflow)
    );

    uart_tx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .avail      (!store_empty),
        .din        (head_byte),
        .data_sel   (data_sel),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .pop        (pop),
        .busy       (busy),
        .txd        (txd)
    );

    uart_tx_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .empty  (store_empty),
        .wr_en  (wr_en),
        .isr_rd (isr_rd),
        .irq_en (irq_en),
        .irq    (txe_irq)
    );

    assign thr_empty = store_empty;
    assign tx_empty  = store_empty && !busy;

    AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty); // R8
    AST_LINE_HIGH_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd); // R8
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        store_full |-> !thr_empty); // R6

endmodule

// File: tb/sim_uart_tx_path.sv
module sim_uart_tx_path;
    localparam int TDIV = 4;
    localparam int BITC = 16 * TDIV;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       fifo_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] data_sel = 2'b11;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       irq_en = 1'b0;
    logic       isr_rd = 1'b0;
    logic       txd, thr_empty, tx_empty, txe_irq, overflow;

    uart_tx_path u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_en(fifo_en),
        .wr_en(wr_en), .wr_data(wr_data), .data_sel(data_sel),
        .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
        .irq_en(irq_en), .isr_rd(isr_rd), .txd(txd), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .txe_irq(txe_irq), .overflow(overflow)
    );

    typedef struct {
        logic [7:0] data;
        logic [1:0] sel;
        logic       pen;
        logic       podd;
        logic       two;
    } exp_t;

    exp_t    sb[$];
    longint  starts[$];
    longint  cyc = 0;
    int      n_checks = 0;
    int      n_fail = 0;
    bit      tick_on = 1'b0;
    int      divc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tick_on) begin
            tick16 <= (divc == TDIV - 1);
            divc   <= (divc == TDIV - 1) ? 0 : divc + 1;
        end else begin
            tick16 <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: decode each frame from the line and compare with the scoreboard head.
    exp_t       m_e;
    logic [7:0] m_got;
    logic       m_par;
    logic       m_stop_ok;
    logic       m_start_ok;
    logic [7:0] m_mask;
    logic       m_exp_par;
    int         m_n;
    bit         m_known;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                starts.push_back(cyc);
                m_known = (sb.size() != 0);
                if (m_known) begin
                    m_e = sb.pop_front();
                end else begin
                    m_e.data = '0; m_e.sel = data_sel; m_e.pen = parity_en;
                    m_e.podd = parity_odd; m_e.two = two_stop;
                end
                repeat (BITC / 2) @(negedge clk);
                m_start_ok = (txd == 1'b0);
                m_n   = 5 + int'(m_e.sel);
                m_got = '0;
                for (int i = 0; i < m_n; i++) begin
                    repeat (BITC) @(negedge clk);
                    m_got[i] = txd;
                end
                m_par = 1'b0;
                if (m_e.pen) begin
                    repeat (BITC) @(negedge clk);
                    m_par = txd;
                end
                m_stop_ok = 1'b1;
                for (int s = 0; s < (m_e.two ? 2 : 1); s++) begin
                    repeat (BITC) @(negedge clk);
                    m_stop_ok = m_stop_ok && (txd == 1'b1);
                end
                check(m_known, "R2", "frame with no byte expected", int'(m_got), -1);
                if (m_known) begin
                    m_mask = 8'hFF >> (3 - int'(m_e.sel));
                    check(m_got == (m_e.data & m_mask), "R2", "data bits LSB first",
                          int'(m_got), int'(m_e.data & m_mask));
                    check(m_start_ok && m_stop_ok, "R2", "start 0 and stop 1",
                          int'({m_start_ok, m_stop_ok}), 3);
                    if (m_e.pen) begin
                        m_exp_par = (^(m_e.data & m_mask)) ^ m_e.podd;
                        check(m_par == m_exp_par, "R3", "parity bit",
                              int'(m_par), int'(m_exp_par));
                    end
                end
            end
        end
    end

    task automatic do_reset();
        tick_on = 1'b0;
        rst_n   = 1'b0;
        fifo_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] b, input bit expect_tx);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        if (expect_tx) begin
            exp_t e;
            e.data = b; e.sel = data_sel; e.pen = parity_en;
            e.podd = parity_odd; e.two = two_stop;
            sb.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_isr();
        @(negedge clk);
        isr_rd = 1'b1;
        @(negedge clk);
        isr_rd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while (!(sb.size() == 0 && tx_empty) && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        check(n < 40000, req, "drain within time limit", n, 40000);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        summary();
    end

    initial begin
        // R1 reset state
        do_reset();
        check(txd == 1'b1, "R1", "txd idle", int'(txd), 1);
        check(thr_empty && tx_empty, "R1", "empty flags", int'({thr_empty, tx_empty}), 3);
        check(!txe_irq && !overflow, "R1", "irq and overflow low",
              int'({txe_irq, overflow}), 0);

        // Single-slot mode, 8 data bits, no parity, one stop
        irq_en  = 1'b1;
        tick_on = 1'b1;
        host_write(8'hA5, 1'b1);
        check(!thr_empty, "R5", "slot held after write", int'(thr_empty), 0);
        repeat (2 * TDIV) @(negedge clk);
        check(thr_empty, "R5", "slot freed when shifter takes byte", int'(thr_empty), 1);
        check(!tx_empty, "R8", "tx_empty low while shifting", int'(tx_empty), 0);
        check(txe_irq, "R9", "irq after slot empties", int'(txe_irq), 1);
        pulse_isr();
        check(!txe_irq, "R10", "status read clears irq", int'(txe_irq), 0);
        host_write(8'h3C, 1'b1);
        check(!thr_empty, "R5", "second byte waits", int'(thr_empty), 0);
        check(!overflow, "R7", "no overflow yet", int'(overflow), 0);
        host_write(8'hFF, 1'b0);
        check(overflow, "R7", "write to full slot flags overflow", int'(overflow), 1);
        wait_idle("R5");
        check(tx_empty && thr_empty, "R8", "quiet after drain",
              int'({tx_empty, thr_empty}), 3);
        check(overflow, "R7", "overflow sticky", int'(overflow), 1);
        check(txe_irq, "R9", "irq pending after second byte taken", int'(txe_irq), 1);

        // Formats: 5 bits odd parity two stops, 7 bits even parity, 6 bits two stops
        data_sel = 2'b00; parity_en = 1'b1; parity_odd = 1'b1; two_stop = 1'b1;
        host_write(8'hF6, 1'b1);
        check(!txe_irq, "R10", "host write clears irq", int'(txe_irq), 0);
        wait_idle("R3");
        host_write(8'h13, 1'b1);
        wait_idle("R3");
        data_sel = 2'b10; parity_odd = 1'b0; two_stop = 1'b0;
        host_write(8'h55, 1'b1);
        wait_idle("R3");
        host_write(8'h81, 1'b1);
        wait_idle("R3");
        data_sel = 2'b01; parity_en = 1'b0; two_stop = 1'b1;
        host_write(8'h2B, 1'b1);
        wait_idle("R2");

        // Queue mode: fill with ticks stopped, push one too many, then drain
        do_reset();
        data_sel = 2'b11; parity_en = 1'b0; two_stop = 1'b0;
        fifo_en = 1'b1;
        repeat (3) @(negedge clk);
        starts.delete();
        for (int i = 0; i < 16; i++) begin
            host_write(8'(i * 17 + 3), 1'b1);
        end
        check(!thr_empty && !overflow, "R6", "16 bytes held without overflow",
              int'({thr_empty, overflow}), 0);
        host_write(8'hEE, 1'b0);
        check(overflow, "R7", "17th write dropped", int'(overflow), 1);
        tick_on = 1'b1;
        repeat (4 * BITC) @(negedge clk);
        check(!thr_empty, "R6", "queue still holds bytes", int'(thr_empty), 0);
        wait_idle("R6");
        check(thr_empty, "R6", "queue empty after drain", int'(thr_empty), 1);
        check(starts.size() == 16, "R11", "frame count", starts.size(), 16);
        for (int i = 1; i < starts.size(); i++) begin
            check(starts[i] - starts[i-1] == longint'(10 * BITC), "R11",
                  "start spacing back to back",
                  int'(starts[i] - starts[i-1]), 10 * BITC);
        end

        // Mode change discards waiting bytes
        tick_on = 1'b0;
        repeat (2) @(negedge clk);
        pulse_isr();
        for (int i = 0; i < 3; i++) begin
            host_write(8'h40 + 8'(i), 1'b0);
        end
        check(!thr_empty, "R12", "bytes waiting before mode change", int'(thr_empty), 0);
        fifo_en = 1'b0;
        @(negedge clk);
        check(thr_empty, "R12", "flush empties store", int'(thr_empty), 1);
        @(negedge clk);
        irq_en = 1'b0;
        @(negedge clk);
        check(!txe_irq, "R9", "irq masked when disabled", int'(txe_irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(txe_irq, "R9", "pending event shows when enabled", int'(txe_irq), 1);
        tick_on = 1'b1;
        starts.delete();
        repeat (20 * BITC) @(negedge clk);
        check(starts.size() == 0 && txd && tx_empty, "R12",
              "no frame from discarded bytes", starts.size(), 0);

        summary();
    end
endmodule